// File: doc/BRIEF.md
# Repeated-Primitive Suppressor with CRC Fault Injection

This block sits in a serial link's transmit path, one register stage ahead of the encoder. It takes one 32-bit word per clock. Each word carries three tags: primitive, CRC word and end of frame. When compression is enabled, a long run of the same primitive is cut short. The first two copies go out literally. The third is replaced by a CONT primitive, and every further copy is replaced by a filler word. The run ends at the first word that differs, and that word is sent unchanged.

By default the filler is pseudo-random junk from a 16-bit LFSR. A debug control replaces the junk with a fixed, easily recognised pattern.

Two edge-armed controls let a test inject CRC faults:
- A rising edge on the transmit control makes the next CRC word leave inverted, for one frame only.
- A rising edge on the receive control produces a single-cycle forced CRC-error strobe for the frame currently being received.

Top module: `cont_sq_tx`

## Requirements
- R1: While rst_ni is low, and in the first cycle after reset, out_word_o, out_prim_o, out_eof_o and rx_crc_err_o are 0, and the filler LFSR state is 16'hFFFF.
- R2: With cont_en_i low, every primitive is sent literally, however long the run of identical primitives.
- R3: With cont_en_i high, the third consecutive identical primitive is replaced by CONT, which is 32'h9999AA7C with out_prim_o high. Two consecutive primitives match when both have in_prim_i high and equal in_word_i.
- R4: With cont_en_i high and dbg_fill_i low, each copy after CONT in the same run is replaced by a junk word with out_prim_o low. The LFSR is 16-bit Fibonacci: next = {s[14:0], s[15]^s[14]^s[12]^s[3]}. Each junk word is {s1, s2}, where s1 is one step from the current state and s2 is one step from s1. The state then becomes s2. The LFSR advances only when a junk word is sent.
- R5: With dbg_fill_i high, filler words are 32'hDEADBEEF and the LFSR does not advance.
- R6: A different primitive, or any word with in_prim_i low, ends the run and is sent unchanged. A data word clears the run count, so CONT needs three new identical primitives after it.
- R7: Each 0-to-1 change of tx_bad_crc_i arms one request, registered at that clock edge. The next word with in_crc_i high (and in_prim_i low) in a later cycle is sent bitwise inverted, and that consumes the request. Holding the control high does not corrupt any later CRC word.
- R8: A 0-to-1 change of rx_bad_crc_i makes rx_crc_err_o high for exactly one cycle, registered at the edge that samples the change. A level held high gives no further pulse.
- R9: Every output is registered one clock after the input word it belongs to. out_eof_o repeats in_eof_i with that one-cycle delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_word_i | input | 32 | Incoming word |
| in_prim_i | input | 1 | Word is a primitive |
| in_crc_i | input | 1 | Word is a frame CRC |
| in_eof_i | input | 1 | Word ends a frame |
| cont_en_i | input | 1 | Enable run compression |
| dbg_fill_i | input | 1 | Constant debug filler instead of junk |
| tx_bad_crc_i | input | 1 | Rising edge arms one inverted CRC |
| rx_bad_crc_i | input | 1 | Rising edge forces a receive CRC error |
| out_word_o | output | 32 | Transmitted word |
| out_prim_o | output | 1 | Transmitted word is a primitive |
| out_eof_o | output | 1 | Transmitted word ends a frame |
| rx_crc_err_o | output | 1 | Forced receive CRC error strobe |

## Verification
The properties assume that the CONT encoding never arrives as an input primitive, and that the CRC tag is never set together with the primitive tag. The stimulus respects both. It uses distinct ordinary primitive codes, and raises the CRC tag only on data words that close a frame.

The properties also assume that every input is low while reset is held. The bench keeps all inputs at zero until reset is released, which lets the checks that look one cycle back hold from the first clock after reset.

// File: rtl/cont_sq_pkg.sv
package cont_sq_pkg;
  localparam logic [31:0] CONT_WORD = 32'h9999AA7C;
  localparam logic [31:0] DBG_WORD  = 32'hDEADBEEF;

  typedef enum logic [1:0] {
    SEL_LIT  = 2'd0,
    SEL_CONT = 2'd1,
    SEL_FILL = 2'd2
  } sel_e;
endpackage

// File: rtl/cont_sq_edge.sv
module cont_sq_edge #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= lvl_i;
  end

  for (genvar g = 0; g < W; g++) begin : g_rise
    assign rise_o[g] = lvl_i[g] & ~lvl_q[g];
  end
endmodule

// File: rtl/cont_sq_run.sv
module cont_sq_run
  import cont_sq_pkg::*;
#(
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned CONT_AFTER = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  input  logic              prim_i,
  input  logic              cont_en_i,
  output sel_e              sel_o
);
  localparam int unsigned CNT_W = $clog2(CONT_AFTER + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(CONT_AFTER);

  logic [WORD_W-1:0] last_q;
  logic [CNT_W-1:0]  run_q, run_d;
  logic              squash_q, squash_d;
  logic              match;

  assign match = prim_i && (run_q != '0) && (word_i == last_q);

  always_comb begin
    if (!prim_i)              run_d = '0;
    else if (!match)          run_d = CNT_W'(1);
    else if (run_q < CNT_MAX) run_d = run_q + CNT_W'(1);
    else                      run_d = run_q;
  end

  always_comb begin
    sel_o    = SEL_LIT;
    squash_d = 1'b0;
    if (cont_en_i && match) begin
      if (squash_q) begin
        sel_o    = SEL_FILL;
        squash_d = 1'b1;
      end else if (run_q >= CNT_MAX) begin
        sel_o    = SEL_CONT;
        squash_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q   <= '0;
      run_q    <= '0;
      squash_q <= 1'b0;
    end else begin
      if (prim_i) last_q <= word_i;
      run_q    <= run_d;
      squash_q <= squash_d;
    end
  end
endmodule

// File: rtl/cont_sq_fill.sv
module cont_sq_fill #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned LFSR_W = 16,
  parameter logic [LFSR_W-1:0] TAPS = 16'hD008,
  parameter logic [LFSR_W-1:0] SEED = 16'hFFFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  output logic [WORD_W-1:0] junk_o
);
  localparam int unsigned STEPS = WORD_W / LFSR_W;

  logic [LFSR_W-1:0] st_q;
  logic [LFSR_W-1:0] chain [STEPS+1];

  assign chain[0] = st_q;

  for (genvar k = 0; k < STEPS; k++) begin : g_step
    assign chain[k+1] = {chain[k][LFSR_W-2:0], ^(chain[k] & TAPS)};
    assign junk_o[WORD_W-1-k*LFSR_W -: LFSR_W] = chain[k+1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    st_q <= SEED;
    else if (adv_i) st_q <= chain[STEPS];
  end
endmodule

// File: rtl/cont_sq_tx.sv
module cont_sq_tx
  import cont_sq_pkg::*;
#(
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned LFSR_W     = 16,
  parameter int unsigned CONT_AFTER = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] in_word_i,
  input  logic              in_prim_i,
  input  logic              in_crc_i,
  input  logic              in_eof_i,
  input  logic              cont_en_i,
  input  logic              dbg_fill_i,
  input  logic              tx_bad_crc_i,
  input  logic              rx_bad_crc_i,
  output logic [WORD_W-1:0] out_word_o,
  output logic              out_prim_o,
  output logic              out_eof_o,
  output logic              rx_crc_err_o
);
  localparam int unsigned N_CTL = 2;
  localparam int unsigned I_TX  = 0;
  localparam int unsigned I_RX  = 1;

  sel_e              sel;
  logic [N_CTL-1:0]  rise;
  logic [WORD_W-1:0] junk;
  logic              junk_adv;
  logic              pend_q;
  logic              crc_hit;
  logic [WORD_W-1:0] word_d;
  logic              prim_d;

  cont_sq_edge #(.W(N_CTL)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  ({rx_bad_crc_i, tx_bad_crc_i}),
    .rise_o (rise)
  );

  cont_sq_run #(.WORD_W(WORD_W), .CONT_AFTER(CONT_AFTER)) u_run (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .word_i    (in_word_i),
    .prim_i    (in_prim_i),
    .cont_en_i (cont_en_i),
    .sel_o     (sel)
  );

  assign junk_adv = (sel == SEL_FILL) && !dbg_fill_i;

  cont_sq_fill #(.WORD_W(WORD_W), .LFSR_W(LFSR_W)) u_fill (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (junk_adv),
    .junk_o (junk)
  );

  assign crc_hit = (sel == SEL_LIT) && in_crc_i && !in_prim_i && pend_q;

  always_comb begin
    unique case (sel)
      SEL_CONT: begin word_d = CONT_WORD; prim_d = 1'b1; end
      SEL_FILL: begin word_d = dbg_fill_i ? DBG_WORD : junk; prim_d = 1'b0; end
      default:  begin
        word_d = crc_hit ? ~in_word_i : in_word_i;
        prim_d = in_prim_i;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_word_o   <= '0;
      out_prim_o   <= 1'b0;
      out_eof_o    <= 1'b0;
      rx_crc_err_o <= 1'b0;
      pend_q       <= 1'b0;
    end else begin
      out_word_o   <= word_d;
      out_prim_o   <= prim_d;
      out_eof_o    <= in_eof_i;
      rx_crc_err_o <= rise[I_RX];
      if (rise[I_TX])   pend_q <= 1'b1;
      else if (crc_hit) pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cont_sq_chk.sv
module cont_sq_chk
  import cont_sq_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [WORD_W-1:0] in_word_i,
  input logic              in_prim_i,
  input logic              in_crc_i,
  input logic              in_eof_i,
  input logic              cont_en_i,
  input logic              dbg_fill_i,
  input logic              rx_bad_crc_i,
  input logic [WORD_W-1:0] out_word_o,
  input logic              out_prim_o,
  input logic              out_eof_o,
  input logic              rx_crc_err_o
);
  logic live_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;
  end

  p_literal_when_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q && !cont_en_i && in_prim_i |=> out_word_o == $past(in_word_i) && out_prim_o);

  p_cont_needs_enable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q && out_prim_o && out_word_o == CONT_WORD |-> $past(cont_en_i) && $past(in_prim_i));

  p_debug_fill_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q && $past(in_prim_i && cont_en_i && dbg_fill_i) && !out_prim_o |-> out_word_o == DBG_WORD);

  p_data_unchanged_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q && !in_prim_i && !in_crc_i |=> out_word_o == $past(in_word_i) && !out_prim_o);

  p_rx_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_crc_err_o |=> !rx_crc_err_o);

  p_rx_from_level_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q && rx_crc_err_o |-> $past(rx_bad_crc_i));

  p_eof_delay_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q |-> out_eof_o == $past(in_eof_i));
endmodule

bind cont_sq_tx cont_sq_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .in_word_i    (in_word_i),
  .in_prim_i    (in_prim_i),
  .in_crc_i     (in_crc_i),
  .in_eof_i     (in_eof_i),
  .cont_en_i    (cont_en_i),
  .dbg_fill_i   (dbg_fill_i),
  .rx_bad_crc_i (rx_bad_crc_i),
  .out_word_o   (out_word_o),
  .out_prim_o   (out_prim_o),
  .out_eof_o    (out_eof_o),
  .rx_crc_err_o (rx_crc_err_o)
);

// File: tb/cont_sq_tx_bench.sv
module cont_sq_tx_bench;
  localparam logic [31:0] CONT = 32'h9999AA7C;
  localparam logic [31:0] DBG  = 32'hDEADBEEF;
  localparam logic [31:0] P_A  = 32'h4A4A957C;
  localparam logic [31:0] P_B  = 32'hB5B5957C;
  localparam logic [31:0] P_C  = 32'h7575B57C;

  typedef struct {
    logic [31:0] w;
    logic        p;
    logic        e;
    logic        rx;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] in_word = '0;
  logic        in_prim = 1'b0, in_crc = 1'b0, in_eof = 1'b0;
  logic        cont_en = 1'b0, dbg_fill = 1'b0, tx_bad = 1'b0, rx_bad = 1'b0;
  logic [31:0] out_word;
  logic        out_prim, out_eof, rx_err;

  int   n_run = 0, n_fail = 0;
  bit   done = 1'b0;
  exp_t q[$];
  logic [15:0] lfsr_m = 16'hFFFF;

  always #5 clk = ~clk;

  cont_sq_tx u_cont_sq_tx (
    .clk_i(clk), .rst_ni(rst_n),
    .in_word_i(in_word), .in_prim_i(in_prim), .in_crc_i(in_crc), .in_eof_i(in_eof),
    .cont_en_i(cont_en), .dbg_fill_i(dbg_fill), .tx_bad_crc_i(tx_bad), .rx_bad_crc_i(rx_bad),
    .out_word_o(out_word), .out_prim_o(out_prim), .out_eof_o(out_eof), .rx_crc_err_o(rx_err)
  );

  function automatic logic [15:0] step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[14] ^ s[12] ^ s[3]};
  endfunction

  function automatic logic [31:0] next_junk();
    logic [15:0] s1, s2;
    s1 = step(lfsr_m);
    s2 = step(s1);
    lfsr_m = s2;
    return {s1, s2};
  endfunction

  task automatic send(input logic [31:0] w, input logic p, input logic c, input logic e,
                      input logic [31:0] ew, input logic ep, input logic erx, input string tag);
    exp_t x;
    in_word = w; in_prim = p; in_crc = c; in_eof = e;
    @(posedge clk);
    x.w = ew; x.p = ep; x.e = e; x.rx = erx; x.tag = tag;
    q.push_back(x);
    @(negedge clk);
  endtask

  task automatic prim_lit(input logic [31:0] w, input string tag);
    send(w, 1'b1, 1'b0, 1'b0, w, 1'b1, 1'b0, tag);
  endtask

  task automatic data(input logic [31:0] w, input string tag);
    send(w, 1'b0, 1'b0, 1'b0, w, 1'b0, 1'b0, tag);
  endtask

  // monitor: compare result of the word captured at the previous edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t x;
      x = q.pop_front();
      n_run++;
      if (out_word !== x.w || out_prim !== x.p || out_eof !== x.e || rx_err !== x.rx) begin
        n_fail++;
        $display("FAIL %s: got w=%h p=%b e=%b rx=%b exp w=%h p=%b e=%b rx=%b",
                 x.tag, out_word, out_prim, out_eof, rx_err, x.w, x.p, x.e, x.rx);
      end
    end
  end

  initial begin
    #(20000 * 10);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_run++;
    if (out_word !== '0 || out_prim !== 1'b0 || out_eof !== 1'b0 || rx_err !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 in reset: got w=%h p=%b e=%b rx=%b exp all zero",
               out_word, out_prim, out_eof, rx_err);
    end
    rst_n = 1'b1;
    @(negedge clk);
    n_run++;
    if (out_word !== '0 || out_prim !== 1'b0 || rx_err !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 after reset: got w=%h p=%b rx=%b exp zero", out_word, out_prim, rx_err);
    end

    // R2: compression off, long run stays literal
    for (int i = 0; i < 6; i++) prim_lit(P_A, "R2 literal run");

    // R3 R4 R6: compression on
    cont_en = 1'b1;
    data(32'h0000_1234, "R6 data");
    prim_lit(P_B, "R3 first");
    prim_lit(P_B, "R3 second");
    send(P_B, 1'b1, 1'b0, 1'b0, CONT, 1'b1, 1'b0, "R3 cont");
    for (int i = 0; i < 4; i++)
      send(P_B, 1'b1, 1'b0, 1'b0, next_junk(), 1'b0, 1'b0, "R4 junk filler");
    prim_lit(P_C, "R6 new primitive ends run");
    prim_lit(P_C, "R6 second of new run");
    send(P_C, 1'b1, 1'b0, 1'b0, CONT, 1'b1, 1'b0, "R3 cont new run");
    data(32'hCAFE_0001, "R6 data ends filler");

    // R6: data word resets the count
    prim_lit(P_A, "R6 a1");
    prim_lit(P_A, "R6 a2");
    data(32'h0BAD_F00D, "R6 data mid run");
    prim_lit(P_A, "R6 a1 again");
    prim_lit(P_A, "R6 a2 again");
    send(P_A, 1'b1, 1'b0, 1'b0, CONT, 1'b1, 1'b0, "R6 cont after restart");

    // R5: debug filler, LFSR frozen
    dbg_fill = 1'b1;
    for (int i = 0; i < 3; i++)
      send(P_A, 1'b1, 1'b0, 1'b0, DBG, 1'b0, 1'b0, "R5 debug filler");
    dbg_fill = 1'b0;
    send(P_A, 1'b1, 1'b0, 1'b0, next_junk(), 1'b0, 1'b0, "R4 junk resumes unadvanced");

    // R2: disable mid-run returns to literal
    cont_en = 1'b0;
    prim_lit(P_A, "R2 disabled mid run");
    prim_lit(P_A, "R2 disabled mid run 2");
    cont_en = 1'b1;

    // R7: transmit CRC corruption
    tx_bad = 1'b1;
    data(32'h1111_0000, "R7 arm");
    data(32'h2222_0000, "R7 payload");
    send(32'h5A5A_C3C3, 1'b0, 1'b1, 1'b1, ~32'h5A5A_C3C3, 1'b0, 1'b0, "R7 inverted crc R9 eof");
    data(32'h3333_0000, "R7 payload 2");
    send(32'h1234_ABCD, 1'b0, 1'b1, 1'b1, 32'h1234_ABCD, 1'b0, 1'b0, "R7 one frame only");
    send(32'h0F0F_0F0F, 1'b0, 1'b1, 1'b1, 32'h0F0F_0F0F, 1'b0, 1'b0, "R7 held high no effect");
    tx_bad = 1'b0;
    data(32'h4444_0000, "R7 drop");
    tx_bad = 1'b1;
    data(32'h5555_0000, "R7 rearm");
    send(32'hFFFF_0000, 1'b0, 1'b1, 1'b1, 32'h0000_FFFF, 1'b0, 1'b0, "R7 inverted again");

    // R8: forced receive error strobe
    rx_bad = 1'b1;
    send(32'h6666_0000, 1'b0, 1'b0, 1'b0, 32'h6666_0000, 1'b0, 1'b1, "R8 strobe");
    data(32'h7777_0000, "R8 held high no pulse");
    data(32'h8888_0000, "R8 held high no pulse 2");
    rx_bad = 1'b0;
    data(32'h9999_0000, "R8 low");
    rx_bad = 1'b1;
    send(32'hAAAA_0000, 1'b0, 1'b0, 1'b0, 32'hAAAA_0000, 1'b0, 1'b1, "R8 second strobe");
    rx_bad = 1'b0;
    data(32'hBBBB_0000, "R8 back low");

    @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule